// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block turns a single start address into a short run of addresses for a burst access. A load strobe captures the external address and presents it as the first beat. Each following advance strobe steps an internal two-bit beat counter, and the two least-significant address bits then follow one of two orderings: a sequential count that wraps inside the aligned group of four, or an XOR-based order. The bits above the lowest two always stay as they were loaded.

The ordering is picked by a mode input that is fixed for the whole time the block runs. A stop strobe ends a burst that is in progress. While the active-low clock enable is high, the block behaves as if no clock edge occurred. Every output comes straight from a register, so the address is ready one cycle after the strobe that produced it.

Top module: `burst_addr_gen`

## Requirements
- R1: In the cycle after a synchronous reset, `addr_out` is 0 and `burst_act` is 0.
- R2: With `clk_en_n`=0, `stop`=0 and `load`=1, `addr_out` equals `addr_in` one cycle later and `burst_act` is 1. This is beat 0.
- R3: With `order_ilv`=0, beat k of a burst (k = 0..3) has low two bits equal to (start + k) mod 4, where start is the low two bits of the loaded address.
- R4: With `order_ilv`=1, beat k has low two bits equal to start XOR k.
- R5: An advance after beat 3 returns to beat 0, and the sequence then repeats.
- R6: `addr_out[ADDR_W-1:2]` changes only on an accepted load.
- R7: An accepted `stop` clears `burst_act` and holds `addr_out`. If `stop` and `load` are both high in the same cycle, `stop` wins.
- R8: An `advance` while `burst_act`=0 changes neither `addr_out` nor `burst_act`.
- R9: While `clk_en_n`=1, `addr_out` and `burst_act` do not change, whatever `load`, `advance` or `stop` do.
- R10: A load during an active burst restarts at beat 0 from the new address. If `load` and `advance` are both high, `load` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable; when high, all state is frozen |
| load | input | 1 | Capture `addr_in` and start a burst |
| advance | input | 1 | Step to the next beat of the active burst |
| stop | input | 1 | End the burst in progress |
| order_ilv | input | 1 | Static ordering select: 0 = sequential wrap, 1 = XOR order |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current burst address (registered) |
| burst_act | output | 1 | High while a burst is in progress (registered) |

## Verification
The bench sweeps every start offset in both orderings and runs one step past the fourth beat. A design that treats the sequential mode as a plain increment would carry into bit 2 at that point, and one that mixes up the two orderings would go wrong at offsets 1 and 3. Other tests strike at the control paths. A stop made after the middle of a burst, followed by stray advances, catches a design that rebuilds the output from a reset counter. Simultaneous stop and load catches a wrong priority. Strobes under a high clock enable catch any state that leaks through the freeze.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_XOR = 1'b1
  } order_e;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic              advance,
  input  logic              stop,
  output logic [BEAT_W-1:0] beat_nxt,
  output logic              capture,
  output logic              update,
  output logic              act_q
);
  logic [BEAT_W-1:0] beat_q;
  logic              act_nxt;
  logic              step;

  always_comb begin
    capture  = en && !stop && load;
    step     = en && !stop && !load && advance && act_q;
    update   = capture || step;
    beat_nxt = beat_q;
    act_nxt  = act_q;
    if (en && stop) begin
      act_nxt  = 1'b0;
      beat_nxt = '0;
    end else if (capture) begin
      act_nxt  = 1'b1;
      beat_nxt = '0;
    end else if (step) begin
      beat_nxt = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
      act_q  <= 1'b0;
    end else begin
      beat_q <= beat_nxt;
      act_q  <= act_nxt;
    end
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
(
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  input  order_e            order,
  output logic [BEAT_W-1:0] low
);
  logic [BEAT_W-1:0] seq_low;
  logic [BEAT_W-1:0] xor_low;

  assign seq_low = start + beat;

  genvar i;
  generate
    for (i = 0; i < BEAT_W; i++) begin : g_xor
      assign xor_low[i] = start[i] ^ beat[i];
    end
  endgenerate

  assign low = (order == ORD_XOR) ? xor_low : seq_low;
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              update,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [BEAT_W-1:0] low_nxt,
  output logic [ADDR_W-1:0] base_nxt,
  output logic [ADDR_W-1:0] addr_q
);
  logic [ADDR_W-1:0] base_q;

  assign base_nxt = capture ? addr_in : base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      addr_q <= '0;
    end else begin
      base_q <= base_nxt;
      if (update) begin
        addr_q <= {base_nxt[ADDR_W-1:BEAT_W], low_nxt};
      end
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en_n,
  input  logic              load,
  input  logic              advance,
  input  logic              stop,
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              burst_act
);
  logic [BEAT_W-1:0] beat_nxt;
  logic [BEAT_W-1:0] low_nxt;
  logic [ADDR_W-1:0] base_nxt;
  logic              capture;
  logic              update;
  order_e            order;

  assign order = order_e'(order_ilv);

  burst_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .en       (!clk_en_n),
    .load     (load),
    .advance  (advance),
    .stop     (stop),
    .beat_nxt (beat_nxt),
    .capture  (capture),
    .update   (update),
    .act_q    (burst_act)
  );

  burst_order_map u_map (
    .start (base_nxt[BEAT_W-1:0]),
    .beat  (beat_nxt),
    .order (order),
    .low   (low_nxt)
  );

  burst_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
    .clk      (clk),
    .rst      (rst),
    .capture  (capture),
    .update   (update),
    .addr_in  (addr_in),
    .low_nxt  (low_nxt),
    .base_nxt (base_nxt),
    .addr_q   (addr_out)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en_n,
  input logic              load,
  input logic              advance,
  input logic              stop,
  input logic              order_ilv,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic              burst_act
);
  p_load_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && load && !stop) |=> (burst_act && addr_out == $past(addr_in)));

  p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && advance && burst_act && !load && !stop && !order_ilv)
      |=> (addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1)));

  p_upper_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (clk_en_n || !load || stop) |=> $stable(addr_out[ADDR_W-1:2]));

  p_stop_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && stop) |=> (!burst_act && $stable(addr_out)));

  p_idle_advance_r8: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !burst_act && !load) |=> (!burst_act && $stable(addr_out)));

  p_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> ($stable(addr_out) && $stable(burst_act)));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clk_en_n  (clk_en_n),
  .load      (load),
  .advance   (advance),
  .stop      (stop),
  .order_ilv (order_ilv),
  .addr_in   (addr_in),
  .addr_out  (addr_out),
  .burst_act (burst_act)
);

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en_n = 1'b0;
  logic          load = 1'b0;
  logic          advance = 1'b0;
  logic          stop = 1'b0;
  logic          order_ilv = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic          burst_act;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .clk_en_n  (clk_en_n),
    .load      (load),
    .advance   (advance),
    .stop      (stop),
    .order_ilv (order_ilv),
    .addr_in   (addr_in),
    .addr_out  (addr_out),
    .burst_act (burst_act)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic ce_n, input logic ld, input logic adv,
                     input logic st, input logic [AW-1:0] a);
    @(negedge clk);
    clk_en_n = ce_n; load = ld; advance = adv; stop = st; addr_in = a;
    @(posedge clk);
    #1;
    clk_en_n = 1'b0; load = 1'b0; advance = 1'b0; stop = 1'b0;
  endtask

  function automatic int expect_low(input int s, input int k, input int ilv);
    return ilv ? (s ^ (k % 4)) : ((s + k) % 4);
  endfunction

  task automatic do_reset(input logic ilv);
    @(negedge clk);
    rst = 1'b1; order_ilv = ilv;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    int hi;
    logic [AW-1:0] held;
    do_reset(1'b0);
    check("R1 addr", int'(addr_out), 0);
    check("R1 act", int'(burst_act), 0);

    // R3 R4 R5 R6 full sweep of start offsets in both orders
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      for (int s = 0; s < 4; s++) begin
        hi = 8'h5c + s * 8'h14 + m * 4;
        cyc(0, 1, 0, 0, AW'((hi & 8'hfc) | s));
        check("R2 load addr", int'(addr_out), (hi & 8'hfc) | s);
        check("R2 act", int'(burst_act), 1);
        for (int k = 1; k <= 5; k++) begin
          cyc(0, 0, 1, 0, 8'hff);
          check(m ? "R4 xor beat" : "R3 seq beat", int'(addr_out[1:0]),
                expect_low(s, k, m));
          check("R6 upper held", int'(addr_out[AW-1:2]), (hi & 8'hfc) >> 2);
        end
        // k=4 returns to start
        check("R5 wrap act", int'(burst_act), 1);
      end
    end

    // R9 freeze under clock enable high
    do_reset(1'b0);
    cyc(0, 1, 0, 0, 8'h31);
    cyc(0, 0, 1, 0, 8'h00);
    held = addr_out;
    cyc(1, 0, 1, 0, 8'h00);
    check("R9 advance frozen", int'(addr_out), int'(held));
    cyc(1, 1, 0, 0, 8'hee);
    check("R9 load frozen", int'(addr_out), int'(held));
    cyc(1, 0, 0, 1, 8'h00);
    check("R9 stop frozen", int'(burst_act), 1);
    cyc(0, 0, 1, 0, 8'h00);
    check("R9 resumes seq", int'(addr_out), 8'h30 | 3);

    // R7 stop holds address, then R8 stray advances ignored
    cyc(0, 0, 0, 1, 8'h00);
    check("R7 stop act", int'(burst_act), 0);
    check("R7 stop addr", int'(addr_out), 8'h33);
    cyc(0, 0, 1, 0, 8'h00);
    check("R8 idle advance addr", int'(addr_out), 8'h33);
    check("R8 idle advance act", int'(burst_act), 0);
    cyc(0, 0, 1, 0, 8'h00);
    check("R8 second idle advance", int'(addr_out), 8'h33);

    // R7 stop beats simultaneous load
    cyc(0, 1, 0, 1, 8'h99);
    check("R7 stop over load act", int'(burst_act), 0);
    check("R7 stop over load addr", int'(addr_out), 8'h33);

    // R10 reload mid-burst, load beats advance (xor order)
    do_reset(1'b1);
    cyc(0, 1, 0, 0, 8'h46);
    cyc(0, 0, 1, 0, 8'h00);
    check("R4 xor mid", int'(addr_out), 8'h47);
    cyc(0, 1, 1, 0, 8'ha1);
    check("R10 reload addr", int'(addr_out), 8'ha1);
    cyc(0, 0, 1, 0, 8'h00);
    check("R10 beat1 after reload", int'(addr_out), 8'ha0);
    cyc(0, 0, 1, 0, 8'h00);
    check("R10 beat2 after reload", int'(addr_out), 8'ha3);

    // R1 reset mid-burst
    do_reset(1'b1);
    check("R1 reset addr", int'(addr_out), 0);
    check("R1 reset act", int'(burst_act), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule